// File: doc/BRIEF.md
# Padded Single-Wire Frame Transmitter

This block puts frames onto a shared single-wire medium that an external pull-down holds low while nobody drives it. Every byte is sent behind a synchronization pad: a long high level followed by a data-length low level. The byte's eight data bits follow the pad, least significant bit first. A frame opens with three stand-alone pads that let a receiver lock its timing. The data bytes follow, each with its own pad.

Before a frame the block checks whether the medium is free. It listens for one byte time plus a pseudo-random extra delay drawn from a 16-bit LFSR. If it sees any high level in that window it gives up the attempt instead of waiting, and reports this with a one-cycle pulse. A host supplies the frame as a byte stream. The block pulls each byte with a one-cycle take strobe, and a last flag that comes with a byte marks the end of the frame, so a frame may be of any length. A mode select picks one of three bit-timing sets. A clock-cycles-per-microsecond parameter turns microseconds into clock ticks.

Top module: `padwire_tx`

## Requirements
- R1: While reset is asserted and after it is released, `lineOe`, `busy`, `collAvoid` and `byteTake` are all 0, so the line is released.
- R2: `modeSel` gives the timings as (pad µs, data-bit µs). 0 gives (116, 44), 1 gives (92, 40), 2 gives (88, 28), and 3 behaves as 0. One µs lasts `CLKS_PER_US` clock cycles. The mode is latched when a request is accepted.
- R3: A `startReq` sampled high in idle is accepted. `busy` is 1 from the next cycle on. The line stays released for that one arming cycle and for the whole sensing window after it.
- R4: The sensing window lasts (pad + 9·data + extra) µs. The LFSR value L is the seed (1 when the seed is 0) advanced once by L' = {L[14:0], L[15]^L[13]^L[12]^L[10]}, and extra = (L'[7:0]·data) >> 8. The line is driven in the first cycle after the window.
- R5: A high `lineIn` in any sensing cycle ends the attempt. In the next cycle `collAvoid` is 1 for exactly one cycle, `busy` is 0 and the line is released. No byte is taken and the line was never driven.
- R6: A frame begins with three pads. Each pad drives high for the pad time and then low for one data-bit time.
- R7: Each byte is sent as a pad (high for the pad time, low for one data-bit time) and then 8 data bits of one data-bit time each, bit 0 first.
- R8: `byteTake` pulses for one cycle. `byteIn` and `byteLast` are latched at the end of that cycle, just before the byte's pad starts. A frame takes exactly as many bytes as it carries.
- R9: In the cycle after the last data bit of the byte flagged with `byteLast`, `lineOe` and `busy` are 0.
- R10: While a frame is being sent, `startReq` and the `lineIn` level have no effect. The frame completes unchanged, and no new attempt follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeSel | input | 2 | Timing set select |
| seed | input | 16 | Backoff seed, loaded at each accepted request |
| startReq | input | 1 | Request to send a frame |
| byteIn | input | 8 | Next frame byte |
| byteLast | input | 1 | Marks `byteIn` as the final frame byte |
| byteTake | output | 1 | One-cycle strobe: `byteIn`/`byteLast` consumed |
| lineIn | input | 1 | Synchronized level of the medium |
| lineOut | output | 1 | Level to drive on the medium |
| lineOe | output | 1 | Drive enable for the medium |
| busy | output | 1 | Attempt or frame in progress |
| collAvoid | output | 1 | One-cycle pulse: attempt abandoned, medium was in use |

## Verification
The assertions assume that `lineIn` is already synchronized to `clk` and that it reflects the block's own drive while `lineOe` is set. The bench wires the line back as a model bus: the block's own level while it drives, and an external level otherwise. The assertions also assume that `byteIn` and `byteLast` hold steady until `byteTake` has been seen. The bench advances its byte pointer only in the cycle after each take, and it raises the external level only while the block is in its sensing window.

// File: rtl/padwire_pkg.sv
`timescale 1ns/1ps
package padwire_pkg;

  localparam int UsW = 10;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ARM, ST_SENSE, ST_PADHI, ST_PADLO, ST_DATA
  } txState_t;

  typedef enum logic [1:0] {
    SEG_SENSE, SEG_PAD, SEG_DATA
  } segKind_t;

  typedef struct packed {
    logic     arm;
    logic     segLoad;
    segKind_t segKind;
    logic     byteLoad;
    logic     bitShift;
  } dpCtl_t;

  function automatic logic [UsW-1:0] padUsOf(input logic [1:0] m);
    case (m)
      2'd1:    return 10'd92;
      2'd2:    return 10'd88;
      default: return 10'd116;
    endcase
  endfunction

  function automatic logic [UsW-1:0] dataUsOf(input logic [1:0] m);
    case (m)
      2'd1:    return 10'd40;
      2'd2:    return 10'd28;
      default: return 10'd44;
    endcase
  endfunction

  function automatic logic [15:0] lfsrStep(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

endpackage

// File: rtl/padwire_dp.sv
`timescale 1ns/1ps
module padwire_dp
  import padwire_pkg::*;
#(
  parameter int CLKS_PER_US = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  dpCtl_t      ctl,
  input  logic [1:0]  modeSel,
  input  logic [15:0] seed,
  input  logic [7:0]  byteIn,
  input  logic        byteLast,
  output logic        segDone,
  output logic        txBit,
  output logic        lastBit,
  output logic        lastFlag
);

  localparam int PscW = (CLKS_PER_US > 1) ? $clog2(CLKS_PER_US) : 1;
  localparam logic [PscW-1:0] PscMax = PscW'(CLKS_PER_US - 1);

  logic [1:0]      modeQ;
  logic [15:0]     lfsrQ;
  logic [PscW-1:0] pscQ;
  logic [UsW-1:0]  usQ, lenQ;
  logic [7:0]      shQ;
  logic [2:0]      bitCntQ;
  logic            lastQ;

  logic [UsW-1:0]  padUs, dataUs, extraUs, newLen;
  logic [17:0]     extraProd;
  logic [15:0]     seedNz;
  logic            usTick;

  assign padUs     = padUsOf(modeQ);
  assign dataUs    = dataUsOf(modeQ);
  assign extraProd = 18'(lfsrQ[7:0]) * 18'(dataUs);
  assign extraUs   = extraProd[17:8];
  assign seedNz    = (seed == 16'd0) ? 16'd1 : seed;

  always_comb begin
    case (ctl.segKind)
      SEG_SENSE: newLen = padUs + UsW'(9) * dataUs + extraUs;
      SEG_PAD:   newLen = padUs;
      default:   newLen = dataUs;
    endcase
  end

  // attempt setup: latch timing set and draw the backoff value
  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ <= 2'd0;
      lfsrQ <= 16'd1;
    end else if (ctl.arm) begin
      modeQ <= modeSel;
      lfsrQ <= lfsrStep(seedNz);
    end
  end

  // microsecond prescaler and segment timer
  assign usTick  = (pscQ == PscMax);
  assign segDone = usTick && (usQ == lenQ - UsW'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pscQ <= '0;
      usQ  <= '0;
      lenQ <= UsW'(1);
    end else if (ctl.segLoad) begin
      pscQ <= '0;
      usQ  <= '0;
      lenQ <= newLen;
    end else if (usTick) begin
      pscQ <= '0;
      usQ  <= segDone ? '0 : usQ + UsW'(1);
    end else begin
      pscQ <= pscQ + PscW'(1);
    end
  end

  // byte shifter, LSB leaves first
  always_ff @(posedge clk) begin
    if (!rstN) begin
      shQ     <= 8'd0;
      bitCntQ <= 3'd0;
      lastQ   <= 1'b0;
    end else if (ctl.byteLoad) begin
      shQ     <= byteIn;
      bitCntQ <= 3'd0;
      lastQ   <= byteLast;
    end else if (ctl.bitShift) begin
      shQ     <= {1'b0, shQ[7:1]};
      bitCntQ <= bitCntQ + 3'd1;
    end
  end

  assign txBit    = shQ[0];
  assign lastBit  = (bitCntQ == 3'd7);
  assign lastFlag = lastQ;

  AST_TIMER_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    usQ < lenQ);                                                   // R2
  AST_LEN_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    ctl.segLoad |=> lenQ != '0);                                   // R4
  AST_SHIFT_OUT: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.bitShift && !ctl.byteLoad) |=> shQ[7] == 1'b0);           // R7

endmodule

// File: rtl/padwire_ctrl.sv
`timescale 1ns/1ps
module padwire_ctrl
  import padwire_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   startReq,
  input  logic   lineIn,
  input  logic   segDone,
  input  logic   txBit,
  input  logic   lastBit,
  input  logic   lastFlag,
  output dpCtl_t ctl,
  output logic   lineOut,
  output logic   lineOe,
  output logic   busy,
  output logic   collAvoid
);

  txState_t   stQ, stNext;
  logic [1:0] initQ, initNext;
  logic       collQ, collNext;

  always_comb begin
    stNext   = stQ;
    initNext = initQ;
    collNext = 1'b0;
    ctl      = '{arm: 1'b0, segLoad: 1'b0, segKind: SEG_DATA,
                 byteLoad: 1'b0, bitShift: 1'b0};
    case (stQ)
      ST_IDLE: if (startReq) begin
        ctl.arm = 1'b1;
        stNext  = ST_ARM;
      end
      ST_ARM: begin
        ctl.segLoad = 1'b1;
        ctl.segKind = SEG_SENSE;
        stNext      = ST_SENSE;
      end
      ST_SENSE: begin
        if (lineIn) begin
          collNext = 1'b1;
          stNext   = ST_IDLE;
        end else if (segDone) begin
          ctl.segLoad = 1'b1;
          ctl.segKind = SEG_PAD;
          initNext    = 2'd3;
          stNext      = ST_PADHI;
        end
      end
      ST_PADHI: if (segDone) begin
        ctl.segLoad = 1'b1;
        ctl.segKind = SEG_DATA;
        stNext      = ST_PADLO;
      end
      ST_PADLO: if (segDone) begin
        ctl.segLoad = 1'b1;
        if (initQ > 2'd1) begin
          ctl.segKind = SEG_PAD;
          initNext    = initQ - 2'd1;
          stNext      = ST_PADHI;
        end else if (initQ == 2'd1) begin
          ctl.segKind  = SEG_PAD;
          ctl.byteLoad = 1'b1;
          initNext     = 2'd0;
          stNext       = ST_PADHI;
        end else begin
          ctl.segKind = SEG_DATA;
          stNext      = ST_DATA;
        end
      end
      ST_DATA: if (segDone) begin
        ctl.bitShift = 1'b1;
        ctl.segLoad  = 1'b1;
        if (lastBit && lastFlag) begin
          stNext = ST_IDLE;
        end else if (lastBit) begin
          ctl.segKind  = SEG_PAD;
          ctl.byteLoad = 1'b1;
          stNext       = ST_PADHI;
        end else begin
          ctl.segKind = SEG_DATA;
        end
      end
      default: stNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stQ   <= ST_IDLE;
      initQ <= 2'd0;
      collQ <= 1'b0;
    end else begin
      stQ   <= stNext;
      initQ <= initNext;
      collQ <= collNext;
    end
  end

  assign lineOe    = (stQ == ST_PADHI) || (stQ == ST_PADLO) || (stQ == ST_DATA);
  assign lineOut   = (stQ == ST_PADHI) || ((stQ == ST_DATA) && txBit);
  assign busy      = (stQ != ST_IDLE);
  assign collAvoid = collQ;

  AST_ABORT_ON_CARRIER: assert property (@(posedge clk) disable iff (!rstN)
    (stQ == ST_SENSE && lineIn) |=> (collAvoid && !busy && !lineOe)); // R5
  AST_COLL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    collAvoid |=> !collAvoid);                                        // R5
  AST_PAD_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rstN)
    ctl.byteLoad |=> (lineOe && lineOut));                            // R8
  AST_QUIET_BEFORE_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lineOe) |-> $past(stQ == ST_SENSE && !lineIn));             // R3
  AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> !lineOe);                                         // R3

endmodule

// File: rtl/padwire_tx.sv
`timescale 1ns/1ps
module padwire_tx
  import padwire_pkg::*;
#(
  parameter int CLKS_PER_US = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  modeSel,
  input  logic [15:0] seed,
  input  logic        startReq,
  input  logic [7:0]  byteIn,
  input  logic        byteLast,
  output logic        byteTake,
  input  logic        lineIn,
  output logic        lineOut,
  output logic        lineOe,
  output logic        busy,
  output logic        collAvoid
);

  dpCtl_t ctl;
  logic   segDone, txBit, lastBit, lastFlag;

  padwire_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .lineIn(lineIn),
    .segDone(segDone), .txBit(txBit), .lastBit(lastBit), .lastFlag(lastFlag),
    .ctl(ctl), .lineOut(lineOut), .lineOe(lineOe), .busy(busy),
    .collAvoid(collAvoid)
  );

  padwire_dp #(.CLKS_PER_US(CLKS_PER_US)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .modeSel(modeSel), .seed(seed),
    .byteIn(byteIn), .byteLast(byteLast), .segDone(segDone), .txBit(txBit),
    .lastBit(lastBit), .lastFlag(lastFlag)
  );

  assign byteTake = ctl.byteLoad;

endmodule

// File: tb/padwire_tx_test.sv
`timescale 1ns/1ps
module padwire_tx_test;

  localparam int CPU = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  modeSel = 2'd0;
  logic [15:0] seed = 16'd0;
  logic        startReq = 1'b0;
  logic [7:0]  byteIn;
  logic        byteLast;
  logic        byteTake;
  logic        lineIn, lineOut, lineOe, busy, collAvoid;
  logic        lineExt = 1'b0;

  logic [7:0]  fb [4];
  logic [2:0]  byteIdx = 3'd0;
  logic [2:0]  frameLen = 3'd1;
  bit          takePend = 1'b0;
  int          takeCount = 0;
  int          nChecks = 0;
  int          nFail = 0;

  always #2.5 clk = ~clk;

  assign lineIn   = lineOe ? lineOut : lineExt;
  assign byteIn   = fb[byteIdx[1:0]];
  assign byteLast = (byteIdx == frameLen - 3'd1);

  padwire_tx #(.CLKS_PER_US(CPU)) uut (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .seed(seed),
    .startReq(startReq), .byteIn(byteIn), .byteLast(byteLast),
    .byteTake(byteTake), .lineIn(lineIn), .lineOut(lineOut),
    .lineOe(lineOe), .busy(busy), .collAvoid(collAvoid)
  );

  // advance the byte pointer one cycle after each take
  always @(negedge clk) begin
    if (takePend) byteIdx <= byteIdx + 3'd1;
    takePend = byteTake;
    if (byteTake) takeCount++;
  end

  function automatic int padUs(input logic [1:0] m);
    return (m == 2'd1) ? 92 : (m == 2'd2) ? 88 : 116;
  endfunction
  function automatic int dataUs(input logic [1:0] m);
    return (m == 2'd1) ? 40 : (m == 2'd2) ? 28 : 44;
  endfunction
  function automatic int senseCycles(input logic [1:0] m, input logic [15:0] s);
    logic [15:0] l;
    l = (s == 16'd0) ? 16'd1 : s;
    l = {l[14:0], l[15] ^ l[13] ^ l[12] ^ l[10]};
    return (padUs(m) + 9 * dataUs(m) + ((int'(l[7:0]) * dataUs(m)) >> 8)) * CPU;
  endfunction

  task automatic checkEq(input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic seg(input logic v, input int cyc, input bit poke, output int errs);
    errs = 0;
    for (int c = 0; c < cyc; c++) begin
      @(negedge clk);
      if (!(lineOe && lineOut == v)) errs++;
      if (poke) startReq = (c == 0);
    end
    if (poke) startReq = 1'b0;
  endtask

  task automatic startAttempt(input logic [1:0] m, input logic [15:0] s);
    @(negedge clk);
    modeSel   = m;
    seed      = s;
    byteIdx   = 3'd0;
    takeCount = 0;
    startReq  = 1'b1;
    @(negedge clk);
    startReq  = 1'b0;
  endtask

  // {mode, seed, length, byte0, byte1, byte2, byte3}
  localparam logic [52:0] VEC [6] = '{
    {2'd0, 16'hACE1, 3'd1, 8'hA5, 8'h00, 8'h00, 8'h00},
    {2'd1, 16'h0000, 3'd2, 8'h00, 8'hFF, 8'h00, 8'h00},
    {2'd2, 16'h1234, 3'd3, 8'h01, 8'h80, 8'h3C, 8'h00},
    {2'd3, 16'hFFFF, 3'd1, 8'h5A, 8'h00, 8'h00, 8'h00},
    {2'd2, 16'h8001, 3'd4, 8'h00, 8'h00, 8'h00, 8'h00},
    {2'd1, 16'h7777, 3'd2, 8'hC3, 8'h96, 8'h00, 8'h00}
  };

  task automatic runFrame(input logic [52:0] v);
    logic [1:0] m;
    int pu, du, sc, badQ, badI, badD, e, idleBad;
    m  = v[52:51];
    for (int i = 0; i < 4; i++) fb[i] = v[31 - 8*i -: 8];
    frameLen = v[34:32];
    pu = padUs(m) * CPU;
    du = dataUs(m) * CPU;
    sc = senseCycles(m, v[50:35]);
    startAttempt(m, v[50:35]);
    checkEq("R3 busy after request", int'(busy), 1);
    badQ = 0;
    for (int k = 1; k <= sc; k++) begin
      @(negedge clk);
      if (lineOe || !busy) badQ++;
    end
    checkEq("R3 line released while sensing", badQ, 0);
    @(negedge clk);
    checkEq("R4 drive starts right after window", int'(lineOe && lineOut), 1);
    badI = 0;
    seg(1'b1, pu - 1, 1'b0, e); badI += e;
    seg(1'b0, du, 1'b0, e);     badI += e;
    for (int p = 1; p < 3; p++) begin
      seg(1'b1, pu, p == 1, e); badI += e;
      seg(1'b0, du, 1'b0, e);   badI += e;
    end
    checkEq("R2 R6 initializer pads", badI, 0);
    badD = 0;
    for (int i = 0; i < int'(v[34:32]); i++) begin
      seg(1'b1, pu, 1'b0, e); badD += e;
      seg(1'b0, du, 1'b0, e); badD += e;
      for (int j = 0; j < 8; j++) begin
        seg(fb[i][j], du, 1'b0, e); badD += e;
      end
    end
    checkEq("R7 byte waveform", badD, 0);
    @(negedge clk);
    checkEq("R9 released after last bit", int'(lineOe || busy), 0);
    checkEq("R8 bytes taken", takeCount, int'(v[34:32]));
    idleBad = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (busy) idleBad++;
    end
    checkEq("R10 request during frame ignored", idleBad, 0);
  endtask

  task automatic abortAt(input logic [1:0] m, input logic [15:0] s, input int k);
    int sawOe;
    sawOe = 0;
    startAttempt(m, s);
    for (int j = 1; j <= k; j++) begin
      @(negedge clk);
      if (lineOe) sawOe++;
      if (j == k) lineExt = 1'b1;
    end
    @(negedge clk);
    checkEq("R5 abandon after carrier", int'(collAvoid && !busy && !lineOe), 1);
    @(negedge clk);
    checkEq("R5 pulse is one cycle", int'(collAvoid), 0);
    lineExt = 1'b0;
    checkEq("R5 no byte taken, no drive", takeCount + sawOe, 0);
    repeat (5) @(negedge clk);
  endtask

  initial begin
    fb[0] = 8'h00; fb[1] = 8'h00; fb[2] = 8'h00; fb[3] = 8'h00;
    repeat (3) @(negedge clk);
    checkEq("R1 outputs during reset", int'({lineOe, busy, collAvoid, byteTake}), 0);
    rstN = 1'b1;
    @(negedge clk);
    checkEq("R1 outputs after reset", int'({lineOe, busy, collAvoid, byteTake}), 0);

    foreach (VEC[i]) runFrame(VEC[i]);

    fb[0] = 8'h11; frameLen = 3'd1;
    abortAt(2'd0, 16'h1357, 5);
    abortAt(2'd2, 16'h2468, senseCycles(2'd2, 16'h2468));
    abortAt(2'd1, 16'h0000, 1);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule